// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Pending Unit

This unit sits next to a two-channel serial controller and collects its interrupt requests. Each channel raises three kinds of request: external/status, transmit and receive. Every request passes through enable fields that the host programs in per-channel configuration registers. The requests that pass are held in a six-bit pending register. A single interrupt line is driven while any pending bit is set and the master enable is on.

The host reaches the unit over a small register bus. An access is qualified by a channel select (A or B) and a register number. Reading the vector register through channel B acknowledges an interrupt. The read returns the programmed base vector with a reason code placed in bits 3:1, and it clears only the pending bit that won the fixed priority. Reading register 3 through channel A returns the raw pending bits. The unit also keeps a per-channel hunting flag, which is set when the host drains the last byte of the receive FIFO and cleared when a new frame starts.

Top module: `sio_irq_pending`

## Requirements
- R1: After a synchronous active-low reset, every configuration register and every pending bit is zero, irq is low, and a register-3 read through channel A returns 0. Pending layout: bit0 B ext/status, bit1 B transmit, bit2 B receive, bit3 A ext/status, bit4 A transmit, bit5 A receive.
- R2: A DCD change pulse on a channel sets that channel's ext/status bit only if bit 3 of that channel's register 15 is 1.
- R3: A receive frame-start pulse sets the channel's receive bit only when the receive mode field, bits 4:3 of the channel's register 1, is 01 or 10. Modes 00 and 11 leave the bit clear.
- R4: A data-read pulse with fifo_nonempty high sets the receive bit only when the mode field is 10. With fifo_nonempty low it sets nothing.
- R5: A frame-start pulse sets the ext/status bit when bit 4 of the channel's register 15 is 1, and it always clears that channel's hunting flag.
- R6: A last-byte pulse sets the channel's hunting flag. It also sets the ext/status bit when bit 7 of the channel's register 15 is 1.
- R7: A transmit-empty pulse sets the transmit bit only if bit 1 of the channel's register 1 is 1. Writing register 0 through a channel with bits 5:3 = 101 clears only that channel's transmit bit.
- R8: A register-2 read through channel B acknowledges an interrupt. Priority runs from B ext (code 1) to A ext (code 5) to A receive (code 6) to B receive (code 2). The read returns the base vector with bits 3:1 replaced by the code, and only the chosen bit is cleared.
- R9: If none of those four sources is pending, the acknowledge read returns the base vector unchanged and clears nothing. A register-2 read through channel A returns the base vector and never acknowledges.
- R10: irq is high exactly when some pending bit is set and the master enable, bit 3 of register 9, is 1.
- R11: A register-3 read through channel A returns the pending bits with the upper bits zero. The same read through channel B returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (the acknowledge side effect happens at the clock edge) |
| reg_chan_a | input | 1 | 1 selects channel A, 0 selects channel B |
| reg_addr | input | AW | Register number |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid combinationally while reg_rd is high |
| dcd_chg | input | 2 | DCD level change pulse, index 1 = A, 0 = B |
| rx_start | input | 2 | Receive frame-start pulse |
| rx_read | input | 2 | Host read a data byte |
| fifo_nonempty | input | 2 | Receive FIFO still holds data, qualifies rx_read |
| last_byte | input | 2 | Host read the last remaining byte |
| tx_empty | input | 2 | Transmit buffer became empty |
| hunting | output | 2 | Per-channel hunting flag |
| irq | output | 1 | Interrupt request |

## Verification
Each enable field is tried with its enable bit clear and then set, so that a source that ignores its gate shows up as a spurious pending bit. The receive mode field is driven through all four codes, both on frame start and on data reads, which separates the one-shot mode from the repeat mode. The acknowledge ordering is tested by loading all four prioritised sources at once and draining them one by one, reading the pending register after each step. This exposes a wrong code, a wrong order, or a clear that hits the wrong bit. Acknowledges with only transmit sources pending, or with nothing pending, confirm that the vector is passed through unchanged.

// File: rtl/sio_irq_pkg.sv
// Shared constants for the serial interrupt pending unit: pending bit
// positions, register numbers, enable field positions and reason codes.
package sio_irq_pkg;
    localparam int NSRC      = 6;
    localparam int SRC_PER_CH = 3;
    // Offsets inside one channel's three-bit group (group 0 = B, 1 = A)
    localparam int OFS_EXT   = 0;
    localparam int OFS_TX    = 1;
    localparam int OFS_RX    = 2;

    // Register numbers
    localparam logic [3:0] ADR_CMD    = 4'd0;
    localparam logic [3:0] ADR_IE     = 4'd1;
    localparam logic [3:0] ADR_VEC    = 4'd2;
    localparam logic [3:0] ADR_PEND   = 4'd3;
    localparam logic [3:0] ADR_MASTER = 4'd9;
    localparam logic [3:0] ADR_EXTEN  = 4'd15;

    // Field positions
    localparam int IE_TX_BIT    = 1;
    localparam int IE_RXM_LO    = 3;
    localparam int EXT_DCD_BIT  = 3;
    localparam int EXT_SYNC_BIT = 4;
    localparam int EXT_BRK_BIT  = 7;
    localparam int MIE_BIT      = 3;
    localparam logic [2:0] CMD_CLR_TX = 3'b101;

    // Acknowledge reason codes
    localparam logic [2:0] CODE_B_EXT = 3'd1;
    localparam logic [2:0] CODE_A_EXT = 3'd5;
    localparam logic [2:0] CODE_A_RX  = 3'd6;
    localparam logic [2:0] CODE_B_RX  = 3'd2;
endpackage

// File: rtl/sio_irq_chan.sv
// Per-channel request gating. Holds the channel's interrupt enable
// register, its ext/status enable register and its hunting flag, and
// turns the raw event pulses into one-cycle set requests.
// Assumes: event pulses are single-cycle and synchronous to clk.
module sio_irq_chan
    import sio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ie_we,
    input  logic       exten_we,
    input  logic [7:0] wdata,
    input  logic       dcd_chg,
    input  logic       rx_start,
    input  logic       rx_read,
    input  logic       fifo_nonempty,
    input  logic       last_byte,
    input  logic       tx_empty,
    output logic       set_ext,
    output logic       set_tx,
    output logic       set_rx,
    output logic       hunting
);
    logic [7:0] ie_q;
    logic [7:0] exten_q;
    logic       hunt_q;
    logic [1:0] rx_mode;
    logic       unused_bits;

    // Hold the two enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q    <= '0;
            exten_q <= '0;
        end else begin
            if (ie_we)    ie_q    <= wdata;
            if (exten_we) exten_q <= wdata;
        end
    end

    // Hunting flag: set on last byte drained, cleared on frame start
    always_ff @(posedge clk) begin
        if (!rst_n)         hunt_q <= 1'b0;
        else if (rx_start)  hunt_q <= 1'b0;
        else if (last_byte) hunt_q <= 1'b1;
    end

    assign rx_mode = ie_q[IE_RXM_LO +: 2];

    // Gate each event through its enable field
    always_comb begin
        set_rx  = (rx_start && (rx_mode == 2'b01 || rx_mode == 2'b10))
               || (rx_read && fifo_nonempty && rx_mode == 2'b10);
        set_ext = (dcd_chg   && exten_q[EXT_DCD_BIT])
               || (rx_start  && exten_q[EXT_SYNC_BIT])
               || (last_byte && exten_q[EXT_BRK_BIT]);
        set_tx  = tx_empty && ie_q[IE_TX_BIT];
    end

    assign hunting     = hunt_q;
    assign unused_bits = ^{ie_q[7:5], ie_q[2], ie_q[0], exten_q[6:5], exten_q[2:0]};
endmodule

// File: rtl/sio_irq_ack.sv
// Fixed-priority acknowledge selector. Picks the winning pending source
// among the four that take part in acknowledge and gives its reason code
// and a one-hot clear mask. Transmit sources never win.
module sio_irq_ack
    import sio_irq_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    output logic            hit,
    output logic [2:0]      code,
    output logic [NSRC-1:0] clr_mask
);
    localparam int B_EXT = 0 * SRC_PER_CH + OFS_EXT;
    localparam int B_RX  = 0 * SRC_PER_CH + OFS_RX;
    localparam int A_EXT = 1 * SRC_PER_CH + OFS_EXT;
    localparam int A_RX  = 1 * SRC_PER_CH + OFS_RX;

    // Priority chain: B ext, A ext, A rx, B rx
    always_comb begin
        hit      = 1'b1;
        code     = '0;
        clr_mask = '0;
        if (pend[B_EXT]) begin
            code = CODE_B_EXT; clr_mask[B_EXT] = 1'b1;
        end else if (pend[A_EXT]) begin
            code = CODE_A_EXT; clr_mask[A_EXT] = 1'b1;
        end else if (pend[A_RX]) begin
            code = CODE_A_RX;  clr_mask[A_RX]  = 1'b1;
        end else if (pend[B_RX]) begin
            code = CODE_B_RX;  clr_mask[B_RX]  = 1'b1;
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/sio_irq_pending.sv
// Interrupt pending unit for a two-channel serial controller. Holds the
// six-bit pending register, the shared base vector and master enable,
// decodes the register bus and performs the acknowledge on vector reads
// through channel B. Assumes: DW >= 8; reg_rdata is combinational and
// read side effects take place on the clock edge ending the read cycle.
module sio_irq_pending
    import sio_irq_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic          reg_chan_a,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [1:0]    dcd_chg,
    input  logic [1:0]    rx_start,
    input  logic [1:0]    rx_read,
    input  logic [1:0]    fifo_nonempty,
    input  logic [1:0]    last_byte,
    input  logic [1:0]    tx_empty,
    output logic [1:0]    hunting,
    output logic          irq
);
    localparam int NCH = 2;

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] tx_clr;
    logic [NSRC-1:0] ack_mask;
    logic [DW-1:0]   vec_q;
    logic            mie_q;
    logic            ack_hit;
    logic [2:0]      ack_code;
    logic            ack_rd;

    // One gating slice per channel; index 1 is channel A
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic sel;
        logic s_ext, s_tx, s_rx;
        assign sel = (reg_chan_a == (ch == 1));

        sio_irq_chan u_chan (
            .clk           (clk),
            .rst_n         (rst_n),
            .ie_we         (reg_wr && sel && reg_addr == AW'(ADR_IE)),
            .exten_we      (reg_wr && sel && reg_addr == AW'(ADR_EXTEN)),
            .wdata         (reg_wdata[7:0]),
            .dcd_chg       (dcd_chg[ch]),
            .rx_start      (rx_start[ch]),
            .rx_read       (rx_read[ch]),
            .fifo_nonempty (fifo_nonempty[ch]),
            .last_byte     (last_byte[ch]),
            .tx_empty      (tx_empty[ch]),
            .set_ext       (s_ext),
            .set_tx        (s_tx),
            .set_rx        (s_rx),
            .hunting       (hunting[ch])
        );

        assign set_vec[ch*SRC_PER_CH + OFS_EXT] = s_ext;
        assign set_vec[ch*SRC_PER_CH + OFS_TX]  = s_tx;
        assign set_vec[ch*SRC_PER_CH + OFS_RX]  = s_rx;
        assign tx_clr[ch*SRC_PER_CH + OFS_EXT]  = 1'b0;
        assign tx_clr[ch*SRC_PER_CH + OFS_RX]   = 1'b0;
        assign tx_clr[ch*SRC_PER_CH + OFS_TX]   = reg_wr && sel
            && reg_addr == AW'(ADR_CMD) && reg_wdata[5:3] == CMD_CLR_TX;
    end

    sio_irq_ack u_ack (
        .pend     (pend_q),
        .hit      (ack_hit),
        .code     (ack_code),
        .clr_mask (ack_mask)
    );

    assign ack_rd = reg_rd && !reg_chan_a && reg_addr == AW'(ADR_VEC);

    // Shared base vector and master enable, writable through either channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            mie_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == AW'(ADR_VEC))    vec_q <= reg_wdata;
            if (reg_addr == AW'(ADR_MASTER)) mie_q <= reg_wdata[MIE_BIT];
        end
    end

    // Pending register: clear acknowledged and commanded bits, new sets win
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(ack_rd ? ack_mask : '0) & ~tx_clr) | set_vec;
    end

    // Read data multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADR_VEC)) begin
            if (!reg_chan_a && ack_hit) reg_rdata = {vec_q[DW-1:4], ack_code, vec_q[0]};
            else                        reg_rdata = vec_q;
        end else if (reg_addr == AW'(ADR_PEND) && reg_chan_a) begin
            reg_rdata = {{(DW-NSRC){1'b0}}, pend_q};
        end
    end

    assign irq = (|pend_q) && mie_q;
endmodule

// File: rtl/sio_irq_pending_chk.sv
// Assertion checker for sio_irq_pending, attached by bind. Watches ports
// plus the pending register and master enable of the top module.
module sio_irq_pending_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_rd,
    input logic       reg_chan_a,
    input logic [3:0] reg_addr,
    input logic [7:0] reg_rdata,
    input logic [1:0] dcd_chg,
    input logic [1:0] rx_start,
    input logic [1:0] rx_read,
    input logic [1:0] last_byte,
    input logic [1:0] tx_empty,
    input logic [5:0] pend,
    input logic       mie,
    input logic       irq
);
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !mie |-> !irq); // R10
    AST_TXB_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[1]) |-> $past(tx_empty[0])); // R7
    AST_RXA_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[5]) |-> $past(rx_start[1] || rx_read[1])); // R3
    AST_EXTA_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[3]) |-> $past(dcd_chg[1] || rx_start[1] || last_byte[1])); // R2
    AST_ACK_B_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_chan_a && reg_addr == 4'd2 && pend[0]
         && !dcd_chg[0] && !rx_start[0] && !last_byte[0]) |=> !pend[0]); // R8
    AST_REG3_CHB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_chan_a && reg_addr == 4'd3) |-> reg_rdata == 8'd0); // R11
endmodule

bind sio_irq_pending sio_irq_pending_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_chan_a (reg_chan_a),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .dcd_chg    (dcd_chg),
    .rx_start   (rx_start),
    .rx_read    (rx_read),
    .last_byte  (last_byte),
    .tx_empty   (tx_empty),
    .pend       (pend_q),
    .mie        (mie_q),
    .irq        (irq)
);

// File: tb/sio_irq_pending_tb.sv
// Scoreboard bench: driver tasks queue expected items, a monitor pops
// and compares them at the falling edge of each probe cycle.
module sio_irq_pending_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_chan_a = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] dcd_chg = '0, rx_start = '0, rx_read = '0;
    logic [1:0] fifo_nonempty = '0, last_byte = '0, tx_empty = '0;
    logic [1:0] hunting;
    logic       irq;
    logic       probe = 1'b0;
    logic       done = 1'b0;
    int         checks = 0;
    int         errors = 0;

    typedef struct {
        int         kind;   // 0 read data, 1 irq, 2 hunting
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    localparam logic [7:0] BASE = 8'hA1;

    always #4 clk = ~clk;

    sio_irq_pending u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_chan_a(reg_chan_a), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dcd_chg(dcd_chg), .rx_start(rx_start),
        .rx_read(rx_read), .fifo_nonempty(fifo_nonempty), .last_byte(last_byte),
        .tx_empty(tx_empty), .hunting(hunting), .irq(irq)
    );

    // Monitor: compare each probed output against the queued expectation
    always @(negedge clk) begin
        if (probe) begin
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty on probe");
            end else begin
                item_t it;
                logic [7:0] got;
                it = sbq.pop_front();
                case (it.kind)
                    0:       got = reg_rdata;
                    1:       got = {7'd0, irq};
                    default: got = {6'd0, hunting};
                endcase
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic wr(input bit a, input logic [3:0] ad, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_chan_a = a; reg_addr = ad; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input bit a, input logic [3:0] ad, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_chan_a = a; reg_addr = ad; probe = 1'b1;
        sbq.push_back('{0, e, tag});
        @(posedge clk); #1;
        reg_rd = 1'b0; probe = 1'b0;
    endtask

    task automatic probe_out(input int kind, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        probe = 1'b1;
        sbq.push_back('{kind, e, tag});
        @(posedge clk); #1;
        probe = 1'b0;
    endtask

    // which: 0 dcd, 1 rx_start, 2 rx_read, 3 last_byte, 4 tx_empty; ch 1 = A
    task automatic pulse(input int which, input int ch, input bit fifo);
        @(posedge clk); #1;
        fifo_nonempty[ch] = fifo;
        case (which)
            0: dcd_chg[ch]   = 1'b1;
            1: rx_start[ch]  = 1'b1;
            2: rx_read[ch]   = 1'b1;
            3: last_byte[ch] = 1'b1;
            default: tx_empty[ch] = 1'b1;
        endcase
        @(posedge clk); #1;
        dcd_chg = '0; rx_start = '0; rx_read = '0; last_byte = '0; tx_empty = '0;
        fifo_nonempty = '0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(1, 4'd3, 8'h00, "R1 pending after reset");
        probe_out(1, 8'h00, "R1 irq after reset");
        probe_out(2, 8'h00, "R1 hunting after reset");
        wr(0, 4'd9, 8'h08);
        wr(1, 4'd2, BASE);

        // R2 DCD gating
        pulse(0, 0, 0);
        rd(1, 4'd3, 8'h00, "R2 dcd masked");
        wr(0, 4'd15, 8'h08);
        pulse(0, 0, 0);
        rd(1, 4'd3, 8'h01, "R2 dcd enabled sets B ext");
        probe_out(1, 8'h01, "R10 irq with mie and pending");
        wr(1, 4'd9, 8'h00);
        probe_out(1, 8'h00, "R10 irq masked by mie");
        wr(1, 4'd9, 8'h08);

        // R8 priority acknowledge with all four sources
        wr(1, 4'd15, 8'h08);
        pulse(0, 1, 0);
        wr(1, 4'd1, 8'h08);
        pulse(1, 1, 0);
        wr(0, 4'd1, 8'h10);
        pulse(1, 0, 0);
        rd(1, 4'd3, 8'h2D, "R8 all four pending");
        rd(1, 4'd2, BASE, "R9 channel A vector read no ack");
        rd(0, 4'd2, 8'hA3, "R8 ack code 1");
        rd(1, 4'd3, 8'h2C, "R8 only B ext cleared");
        rd(0, 4'd2, 8'hAB, "R8 ack code 5");
        rd(1, 4'd3, 8'h24, "R8 only A ext cleared");
        rd(0, 4'd2, 8'hAD, "R8 ack code 6");
        rd(1, 4'd3, 8'h04, "R8 only A rx cleared");
        rd(0, 4'd2, 8'hA5, "R8 ack code 2");
        rd(1, 4'd3, 8'h00, "R8 all cleared");
        rd(0, 4'd2, BASE, "R9 ack with nothing pending");

        // R3 modes 11 and 00 do not set receive
        wr(1, 4'd1, 8'h18);
        pulse(1, 1, 0);
        rd(1, 4'd3, 8'h00, "R3 mode 11 ignored");
        wr(1, 4'd1, 8'h00);
        pulse(1, 1, 0);
        rd(1, 4'd3, 8'h00, "R3 mode 00 ignored");
        wr(1, 4'd1, 8'h10);
        pulse(1, 1, 0);
        rd(1, 4'd3, 8'h20, "R3 mode 10 frame start sets A rx");
        rd(0, 4'd2, 8'hAD, "R3 clear A rx");

        // R4 data-read re-arm
        wr(0, 4'd1, 8'h08);
        pulse(2, 0, 1);
        rd(1, 4'd3, 8'h00, "R4 mode 01 no re-arm");
        wr(0, 4'd1, 8'h10);
        pulse(2, 0, 0);
        rd(1, 4'd3, 8'h00, "R4 fifo empty no re-arm");
        pulse(2, 0, 1);
        rd(1, 4'd3, 8'h04, "R4 mode 10 re-arm");
        rd(0, 4'd2, 8'hA5, "R4 clear B rx");

        // R6 / R5 hunting and sync
        wr(1, 4'd1, 8'h00);
        wr(1, 4'd15, 8'h10);
        pulse(3, 1, 0);
        probe_out(2, 8'h02, "R6 last byte sets A hunting");
        rd(1, 4'd3, 8'h00, "R6 break disabled no ext");
        pulse(1, 1, 0);
        probe_out(2, 8'h00, "R5 frame start clears hunting");
        rd(1, 4'd3, 8'h08, "R5 sync enabled sets A ext");
        rd(0, 4'd2, 8'hAB, "R5 clear A ext");
        wr(0, 4'd15, 8'h80);
        pulse(3, 0, 0);
        probe_out(2, 8'h01, "R6 B hunting");
        rd(1, 4'd3, 8'h01, "R6 break enabled sets B ext");
        rd(0, 4'd2, 8'hA3, "R6 clear B ext");

        // R7 transmit gating and clear command
        pulse(4, 1, 0);
        rd(1, 4'd3, 8'h00, "R7 tx masked");
        wr(1, 4'd1, 8'h02);
        pulse(4, 1, 0);
        wr(0, 4'd1, 8'h02);
        pulse(4, 0, 0);
        rd(1, 4'd3, 8'h12, "R7 both tx pending");
        rd(0, 4'd3, 8'h00, "R11 channel B pending read is zero");
        rd(0, 4'd2, BASE, "R9 only tx pending vector unchanged");
        rd(1, 4'd3, 8'h12, "R9 tx not cleared by ack");
        wr(0, 4'd0, 8'h28);
        rd(1, 4'd3, 8'h10, "R7 B clear leaves A tx");
        probe_out(1, 8'h01, "R10 irq with tx pending");
        wr(1, 4'd0, 8'h28);
        rd(1, 4'd3, 8'h00, "R7 A tx cleared");
        probe_out(1, 8'h00, "R10 irq low when nothing pending");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule